// File: doc/BRIEF.md
# Four-Source Vectored Priority Interrupter

This block collects interrupt causes from four peripheral channels on one card and presents them to a processor bus as a single request line. The channels are served in a fixed order: fast tape reader first, then fast tape punch, then slow reader (keyboard), then slow punch (printer). When the processor acknowledges, the block latches the winning channel's vector. It drives that vector onto the data bus for as long as the vector-read strobe is held, and marks the channel as in service.

In-service flags give nested service. While a level is in service, that level and every lower level are held off. A higher level may still interrupt and nest on top. Each end-of-service pulse retires only the innermost (most recently granted, highest-priority) level, so the interrupted routine resumes with its own flag still set. A chain-busy output tells cards further down a daisy chain that this card holds an in-service level.

Top module: `vec_irq_arbiter`

## Requirements
- R1: Channel index 0 is the fast reader, 1 the fast punch, 2 the slow reader and 3 the slow punch. For channels 0 to 2 a cause is `ie[i] & (rdy[i] | err[i])`. For channel 3 a cause is `ie[3] & rdy[3]`, because that channel has no error input.
- R2: `irq` is high exactly when `mask` is low, no vector is being held for the bus, and at least one channel has a cause that is not locked out.
- R3: On a clock edge with `ack` and `irq` both high, the lowest-index unlocked cause wins. Its in-service flag is set and its vector is latched for the bus.
- R4: With default parameters the vectors are octal 010, 012, 014 and 016 for channels 0, 1, 2 and 3.
- R5: `vec_oe` is high only while a latched vector is held and `vec_rd` is high. While `vec_oe` is high, `vec` carries the latched vector. At all other times `vec` is zero.
- R6: The held vector is released on the first clock edge that sees `vec_rd` low after it was high. Once released, `irq` can rise again.
- R7: While channel k is in service, causes at channels k and above (lower priority) cannot raise `irq`. Causes at channels below k (higher priority) still can, and may be granted, which nests service.
- R8: An `eos` pulse clears only the lowest-index in-service flag. Flags of interrupted lower-priority levels stay set.
- R9: `chain_busy` is high whenever any in-service flag is set.
- R10: `ack` has no effect while `irq` is low, whether that is caused by the mask, by no pending cause, or by a vector still being held.
- R11: After reset no flag is in service, no vector is held, and `irq`, `vec_oe`, `vec` and `chain_busy` are all zero.
- R12: When `ack` (with `irq` high) and `eos` arrive on the same edge, both take effect. The innermost level is cleared and the new, higher-priority level is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdy | input | 4 | Per-channel ready flags, bit 0 highest priority |
| err | input | 3 | Error flags for channels 0 to 2 |
| ie | input | 4 | Per-channel interrupt enables |
| mask | input | 1 | Card-level interrupt mask |
| ack | input | 1 | Interrupt acknowledge from the bus |
| vec_rd | input | 1 | Vector-read strobe |
| eos | input | 1 | End-of-service pulse |
| irq | output | 1 | Interrupt request |
| vec | output | VW | Vector onto the data bus |
| vec_oe | output | 1 | Vector drive enable |
| chain_busy | output | 1 | Some level of this card is in service |

## Verification
A grant and an end-of-service can land on the same edge. This happens when a higher-priority channel interrupts just as the routine below it finishes. The bench provokes it with a directed nest in which `ack` and `eos` are pulsed together. Constrained random traffic also draws both strobes with independent probabilities over thousands of cycles. Every cycle is judged against a bench model of the in-service flags, which applies the clear of the innermost level and the set of the new winner together. The model's expected `irq`, `vec`, `vec_oe` and `chain_busy` are compared at the ports.

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter #(
  parameter int VW = 8,
  parameter logic [VW-1:0] VEC_L0 = VW'(8'o010),
  parameter logic [VW-1:0] VEC_L1 = VW'(8'o012),
  parameter logic [VW-1:0] VEC_L2 = VW'(8'o014),
  parameter logic [VW-1:0] VEC_L3 = VW'(8'o016)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rdy,
  input  logic [2:0]    err,
  input  logic [3:0]    ie,
  input  logic          mask,
  input  logic          ack,
  input  logic          vec_rd,
  input  logic          eos,
  output logic          irq,
  output logic [VW-1:0] vec,
  output logic          vec_oe,
  output logic          chain_busy
);
  logic [3:0] cause, blocked, elig, win, inserv, eos_clr;
  logic [VW-1:0] win_vec, held_vec;
  logic drv, rd_q, take;

  assign cause = ie & (rdy | {1'b0, err});

  for (genvar i = 0; i < 4; i++) begin : g_lock
    assign blocked[i] = |inserv[i:0];
  end

  assign elig    = cause & ~blocked;
  assign win     = elig & (~elig + 4'd1);
  assign eos_clr = inserv & (~inserv + 4'd1);
  assign irq     = ~mask & (|elig) & ~drv;
  assign take    = ack & irq;

  always_comb begin
    unique case (win)
      4'b0001: win_vec = VEC_L0;
      4'b0010: win_vec = VEC_L1;
      4'b0100: win_vec = VEC_L2;
      4'b1000: win_vec = VEC_L3;
      default: win_vec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inserv   <= '0;
      drv      <= 1'b0;
      rd_q     <= 1'b0;
      held_vec <= '0;
    end else begin
      rd_q   <= vec_rd;
      inserv <= (inserv & ~(eos ? eos_clr : 4'b0)) | (take ? win : 4'b0);
      if (take) begin
        drv      <= 1'b1;
        held_vec <= win_vec;
      end else if (rd_q && !vec_rd) begin
        drv <= 1'b0;
      end
    end
  end

  assign vec_oe     = drv & vec_rd;
  assign vec        = vec_oe ? held_vec : '0;
  assign chain_busy = |inserv;
endmodule

module vec_irq_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic mask,
  input logic ack,
  input logic vec_rd,
  input logic eos,
  input logic irq,
  input logic vec_oe,
  input logic chain_busy
);
  p_mask_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);
  p_grant_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> !irq);
  p_grant_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> chain_busy);
  p_grant_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (vec_rd -> vec_oe));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ack && irq) && !eos) |=> $stable(chain_busy));
endmodule

bind vec_irq_arbiter vec_irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mask(mask), .ack(ack), .vec_rd(vec_rd),
  .eos(eos), .irq(irq), .vec_oe(vec_oe), .chain_busy(chain_busy)
);

// File: tb/tb_vec_irq_arbiter.sv
module tb_vec_irq_arbiter;
  logic clk = 0, rst_n = 0;
  logic [3:0] rdy = 0, ie = 0;
  logic [2:0] err = 0;
  logic mask = 0, ack = 0, vec_rd = 0, eos = 0;
  logic irq, vec_oe, chain_busy;
  logic [7:0] vec;
  int tests = 0, fails = 0;
  bit done = 0;

  logic [3:0] m_isr = 0;
  logic m_drv = 0, m_rdq = 0;
  logic [7:0] m_vec = 0;

  always #5 clk = ~clk;

  vec_irq_arbiter dut (.clk(clk), .rst_n(rst_n), .rdy(rdy), .err(err), .ie(ie),
    .mask(mask), .ack(ack), .vec_rd(vec_rd), .eos(eos), .irq(irq), .vec(vec),
    .vec_oe(vec_oe), .chain_busy(chain_busy));

  function automatic logic [3:0] f_elig(logic [3:0] r, logic [2:0] e, logic [3:0] en, logic [3:0] isr);
    logic [3:0] c, el;
    c = en & (r | {1'b0, e});
    el = '0;
    for (int i = 0; i < 4; i++) begin
      logic lk = 0;
      for (int j = 0; j <= i; j++) lk |= isr[j];
      el[i] = c[i] & ~lk;
    end
    return el;
  endfunction

  function automatic int f_first(logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, string nm, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", tag, nm, got, exp);
    end
  endtask

  task automatic step(string tag, logic [3:0] r, logic [2:0] e, logic [3:0] en,
                      logic m, logic a, logic vr, logic eo);
    logic [3:0] el, nisr;
    logic e_irq, ndrv;
    logic [7:0] nvec;
    int w;
    rdy = r; err = e; ie = en; mask = m; ack = a; vec_rd = vr; eos = eo;
    #1;
    el = f_elig(r, e, en, m_isr);
    e_irq = ~m & (|el) & ~m_drv;
    chk(tag, "irq", {7'b0, irq}, {7'b0, e_irq});
    chk(tag, "vec_oe", {7'b0, vec_oe}, {7'b0, m_drv & vr});
    chk(tag, "vec", vec, (m_drv & vr) ? m_vec : 8'h0);
    chk(tag, "chain_busy", {7'b0, chain_busy}, {7'b0, |m_isr});
    nisr = m_isr; ndrv = m_drv; nvec = m_vec;
    if (eo) begin
      w = f_first(m_isr);
      if (w >= 0) nisr[w] = 1'b0;
    end
    if (a && e_irq) begin
      w = f_first(el);
      nisr[w] = 1'b1; ndrv = 1'b1; nvec = 8'o010 + 8'(2 * w);
    end else if (m_rdq && !vr) ndrv = 1'b0;
    @(posedge clk);
    m_isr = nisr; m_drv = ndrv; m_vec = nvec; m_rdq = vr;
    @(negedge clk);
  endtask

  task automatic grant(string tag, logic [3:0] r, logic [2:0] e, logic [3:0] en, logic eo);
    step(tag, r, e, en, 0, 1, 0, eo);
    step(tag, r, e, en, 0, 0, 1, 0);
    step(tag, r, e, en, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "irq", {7'b0, irq}, 8'h0);
    chk("R11", "vec", vec, 8'h0);
    chk("R11", "vec_oe", {7'b0, vec_oe}, 8'h0);
    chk("R11", "chain_busy", {7'b0, chain_busy}, 8'h0);
    rst_n = 1;
    @(negedge clk);
    // R1 slow punch: no error path, ready path
    step("R1", 4'b0000, 3'b000, 4'b1000, 0, 0, 0, 0);
    step("R1", 4'b1000, 3'b000, 4'b1000, 0, 0, 0, 0);
    step("R1", 4'b0000, 3'b100, 4'b0100, 0, 0, 0, 0);
    step("R1", 4'b0000, 3'b100, 4'b0000, 0, 0, 0, 0);
    // R3 R4 R5 R6: all pending, fast reader wins with 010
    grant("R3", 4'b1111, 3'b000, 4'b1111, 0);
    step("R4", 4'b1111, 3'b000, 4'b1111, 0, 1, 0, 0);
    step("R4", 4'b1111, 3'b000, 4'b1111, 0, 0, 0, 1);
    // R7 lockout at own level and below
    grant("R7", 4'b0100, 3'b000, 4'b0100, 0);
    step("R7", 4'b1100, 3'b000, 4'b1100, 0, 1, 0, 0);
    step("R7", 4'b0010, 3'b000, 4'b0010, 0, 0, 0, 0);
    grant("R7", 4'b0010, 3'b000, 4'b0010, 0);
    // R8 eos clears innermost only
    step("R8", 4'b0100, 3'b000, 4'b0100, 0, 0, 0, 1);
    step("R8", 4'b0100, 3'b000, 4'b0100, 0, 0, 0, 0);
    step("R8", 4'b0000, 3'b000, 4'b0000, 0, 0, 0, 1);
    step("R9", 4'b0000, 3'b000, 4'b0000, 0, 0, 0, 0);
    // R10 ack ignored while masked, idle, or holding
    step("R10", 4'b0001, 3'b000, 4'b0001, 1, 1, 0, 0);
    step("R10", 4'b0000, 3'b000, 4'b0000, 0, 1, 0, 0);
    step("R10", 4'b0010, 3'b000, 4'b0010, 0, 1, 1, 0);
    step("R10", 4'b0001, 3'b000, 4'b0001, 0, 1, 1, 0);
    step("R10", 4'b0001, 3'b000, 4'b0001, 0, 0, 0, 0);
    step("R10", 4'b0000, 3'b000, 4'b0000, 0, 0, 0, 1);
    step("R10", 4'b0000, 3'b000, 4'b0000, 0, 0, 0, 0);
    // R12 grant and eos together
    grant("R12", 4'b1000, 3'b000, 4'b1000, 0);
    step("R12", 4'b0001, 3'b000, 4'b0001, 0, 1, 0, 1);
    step("R12", 4'b0001, 3'b000, 4'b0001, 0, 0, 1, 0);
    step("R12", 4'b0000, 3'b000, 4'b0000, 0, 0, 0, 1);
    step("R12", 4'b0000, 3'b000, 4'b0000, 0, 0, 0, 0);
    // R2 constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      step("R2", 4'($urandom), 3'($urandom & $urandom), 4'($urandom | $urandom),
           ($urandom % 8) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0,
           ($urandom % 6) == 0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule